// File: doc/BRIEF.md
# Filtered Edge-Triggered Input Capture

This block timestamps events on an external capture pin. The pin is first brought into the clock domain by a synchroniser. An optional glitch filter can then clean it up. A selected edge of the resulting level copies the free-running counter value supplied by a neighbouring timer into a capture register. The same edge raises a sticky capture flag. An interrupt request follows the flag whenever interrupts are enabled.

Software, or a neighbouring block, reads the captured value and then pulses the clear strobe to acknowledge the event. The filter trades a fixed four-cycle latency for immunity to pulses shorter than four clocks. Edge polarity can be changed at any time without producing an event by itself.

Top module: `icap_unit`

## Requirements
- R1: Synchronous active-high reset forces `cap_value` to 0, `cap_flag` to 0 and `irq` to 0. The pin must be low when reset is released.
- R2: With the filter off, a pin change made before clock edge k triggers at edge k+2 (two synchroniser flops, then edge detection). `cap_value` then holds the `count_val` present at that edge.
- R3: `edge_rise`=1 selects rising edges and `edge_rise`=0 selects falling edges. An edge of the other polarity leaves `cap_value` and `cap_flag` unchanged.
- R4: With `filt_en`=1, the same pin change is captured exactly four clock edges later than without the filter, at edge k+6.
- R5: With `filt_en`=1, the filtered level changes only once four consecutive synchronised samples agree. A pulse lasting three clocks or fewer produces no capture, and a pulse of four clocks does.
- R6: A capture sets `cap_flag`. The flag stays set until a cycle with `flag_clr`=1, after which it reads 0.
- R7: When a capture and `flag_clr` fall on the same clock edge, the capture wins: the flag stays 1 and the new value is stored.
- R8: `irq` equals `cap_flag` AND `irq_en` at all times.
- R9: Toggling `edge_rise` while the pin is steady produces no capture.
- R10: Each capture overwrites the previous value, whether or not the flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_pin | input | 1 | Raw asynchronous capture input |
| filt_en | input | 1 | 1 = route the pin through the four-sample filter |
| edge_rise | input | 1 | 1 = rising edge triggers, 0 = falling edge triggers |
| count_val | input | 16 | Current counter value to be timestamped |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| cap_value | output | 16 | Last captured counter value |
| cap_flag | output | 1 | Sticky capture event flag |
| irq | output | 1 | Interrupt request |

## Verification
The capture path is driven with pulses of one to six clocks, in both polarities, with the filter on and off. A captured stamp exposes the exact trigger edge, so an off-by-one in the synchroniser or the filter latency shows up as a wrong value. Three-clock and four-clock pulses under the filter separate a correct agreement count from one that is a sample short or long. Pulses of the opposite polarity, together with polarity toggles on a steady pin, show that no stray events occur. A capture timed to coincide with the clear strobe resolves the flag priority.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int unsigned CNT_W       = 16;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned FILT_TAPS   = 4;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic             fire;
        logic [CNT_W-1:0] stamp;
    } cap_evt_t;

    // True when every bit of the sample window holds the same level
    function automatic logic window_agrees(input logic [FILT_TAPS-1:0] w);
        return (&w) | ~(|w);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int unsigned STAGES = icap_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int unsigned TAPS = FILT_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned HIST_W = TAPS - 1;

    logic [HIST_W-1:0] hist;
    logic [TAPS-1:0]   window;
    logic              level_q;

    // Current sample plus the previous TAPS-1 samples
    assign window = {hist, din};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= '0;
            level_q <= 1'b0;
        end else begin
            hist <= window[HIST_W-1:0];
            if (window_agrees(window))
                level_q <= din;
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  edge_pol_e pol,
    output logic      fire
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    // Only a real transition of the level can fire; polarity only chooses which
    always_comb begin
        unique case (pol)
            POL_RISE: fire = lvl & ~prev_q;
            POL_FALL: fire = ~lvl & prev_q;
            default:  fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_hold.sv
module icap_hold
    import icap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cap_evt_t         evt,
    input  logic             clr,
    output logic [CNT_W-1:0] value,
    output logic             flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            flag  <= 1'b0;
        end else begin
            if (evt.fire) begin
                value <= evt.stamp;
                flag  <= 1'b1;
            end else if (clr) begin
                flag  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_pin,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic [CNT_W-1:0] count_val,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             irq
);
    logic      pin_sync;
    logic      pin_filt;
    logic      lvl_sel;
    logic      trig;
    edge_pol_e pol;
    cap_evt_t  evt;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (cap_pin),
        .q_sync  (pin_sync)
    );

    // The filter always runs, so its level is current when it is switched in
    icap_filter #(.TAPS(FILT_TAPS)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_sync),
        .dout (pin_filt)
    );

    assign lvl_sel = filt_en ? pin_filt : pin_sync;
    assign pol     = edge_rise ? POL_RISE : POL_FALL;

    icap_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_sel),
        .pol  (pol),
        .fire (trig)
    );

    assign evt.fire  = trig;
    assign evt.stamp = count_val;

    icap_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .clr   (flag_clr),
        .value (cap_value),
        .flag  (cap_flag)
    );

    assign irq = cap_flag & irq_en;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk
    import icap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             edge_rise,
    input logic [CNT_W-1:0] count_val,
    input logic             irq_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             irq,
    input logic             trig,
    input logic             lvl_sel,
    input logic             pin_sync,
    input logic             pin_filt
);
    // R1
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cap_value == '0 && !cap_flag));

    // R6
    assert_value_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_value != $past(cap_value)) |-> cap_flag);

    // R6
    assert_clear_drops_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !trig) |=> !cap_flag);

    // R7
    assert_capture_wins_R7: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cap_flag && cap_value == $past(count_val)));

    // R8
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq == (cap_flag && irq_en));

    // R9
    assert_no_pol_event_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(edge_rise) && $stable(lvl_sel)) |-> !trig);

    // R5
    assert_filter_agree_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_filt) |-> ($past(pin_sync) == pin_filt
                                && $past(pin_sync, 2) == pin_filt));
endmodule

bind icap_unit icap_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .edge_rise (edge_rise),
    .count_val (count_val),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .irq       (irq),
    .trig      (trig),
    .lvl_sel   (lvl_sel),
    .pin_sync  (pin_sync),
    .pin_filt  (pin_filt)
);

// File: tb/sim_icap_unit.sv
module sim_icap_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cap_pin;
    logic        filt_en;
    logic        edge_rise;
    logic [15:0] count_val;
    logic        irq_en;
    logic        flag_clr;
    logic [15:0] cap_value;
    logic        cap_flag;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    icap_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .cap_pin   (cap_pin),
        .filt_en   (filt_en),
        .edge_rise (edge_rise),
        .count_val (count_val),
        .irq_en    (irq_en),
        .flag_clr  (flag_clr),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .irq       (irq)
    );

    typedef struct packed {
        logic       filt;
        logic       rise;
        logic [7:0] len;
        logic       hit;
    } vec_t;

    // filter, polarity, pulse length in clocks, capture expected
    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 8'd5, 1'b1},  // R2 rising
        '{1'b0, 1'b0, 8'd5, 1'b1},  // R2 R3 falling
        '{1'b0, 1'b1, 8'd1, 1'b1},  // R2 short pulse, no filter
        '{1'b0, 1'b0, 8'd2, 1'b1},
        '{1'b1, 1'b1, 8'd6, 1'b1},  // R4
        '{1'b1, 1'b0, 8'd6, 1'b1},  // R4 falling
        '{1'b1, 1'b1, 8'd3, 1'b0},  // R5 rejected
        '{1'b1, 1'b0, 8'd2, 1'b0},  // R5 rejected
        '{1'b1, 1'b1, 8'd4, 1'b1},  // R5 boundary accepted
        '{1'b1, 1'b0, 8'd4, 1'b1},
        '{1'b1, 1'b1, 8'd1, 1'b0}
    };

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<100000 cycles", cycles);
            finish_run();
        end
    end

    task automatic step();
        @(negedge clk);
        count_val = count_val + 16'd1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        step(); flag_clr = 1'b1;
        step(); flag_clr = 1'b0;
    endtask

    initial begin
        logic [15:0] last_val;
        logic [15:0] c_up;
        logic [15:0] c_dn;
        logic [15:0] c0;

        rst = 1'b1; cap_pin = 1'b0; filt_en = 1'b0; edge_rise = 1'b1;
        count_val = 16'h1000; irq_en = 1'b0; flag_clr = 1'b0;
        steps(3);
        chk("R1 value", 32'(cap_value), 32'h0);
        chk("R1 flag",  32'(cap_flag),  32'h0);
        chk("R1 irq",   32'(irq),       32'h0);
        rst = 1'b0;
        last_val = 16'h0;

        for (int v = 0; v < NVEC; v++) begin
            pulse_clr();
            filt_en = VEC[v].filt; edge_rise = VEC[v].rise;
            steps(8);
            step(); cap_pin = 1'b1; c_up = count_val;
            steps(int'(VEC[v].len));
            cap_pin = 1'b0; c_dn = count_val;
            steps(14);
            if (VEC[v].hit)
                last_val = (VEC[v].rise ? c_up : c_dn) + (VEC[v].filt ? 16'd6 : 16'd2);
            chk($sformatf("R2 R3 R4 R5 vec%0d flag", v), 32'(cap_flag), 32'(VEC[v].hit));
            chk($sformatf("R2 R4 R10 vec%0d value", v), 32'(cap_value), 32'(last_val));
        end

        // R7: capture and clear on the same edge; flag already set
        filt_en = 1'b0; edge_rise = 1'b1;
        step(); cap_pin = 1'b1; step(); cap_pin = 1'b0; steps(6);
        chk("R6 flag set", 32'(cap_flag), 32'h1);
        step(); cap_pin = 1'b1; c0 = count_val;
        step();
        step(); flag_clr = 1'b1;  // edge k+2 carries both
        step(); flag_clr = 1'b0;
        chk("R7 flag", 32'(cap_flag), 32'h1);
        chk("R7 R10 value", 32'(cap_value), 32'(c0 + 16'd2));
        last_val = c0 + 16'd2;

        // R8 irq gating
        irq_en = 1'b1; step();
        chk("R8 irq on", 32'(irq), 32'h1);
        irq_en = 1'b0; step();
        chk("R8 irq masked", 32'(irq), 32'h0);
        irq_en = 1'b1;

        // R6 clear alone
        pulse_clr(); step();
        chk("R6 flag cleared", 32'(cap_flag), 32'h0);
        chk("R8 irq after clear", 32'(irq), 32'h0);

        // R9 polarity toggles with the pin steady high
        edge_rise = 1'b0; steps(3);
        edge_rise = 1'b1; steps(3);
        edge_rise = 1'b0; step(); edge_rise = 1'b1; steps(4);
        chk("R9 flag", 32'(cap_flag), 32'h0);
        chk("R9 value", 32'(cap_value), 32'(last_val));

        // R3 falling edge ignored under rising selection
        cap_pin = 1'b0; steps(8);
        chk("R3 fall ignored flag", 32'(cap_flag), 32'h0);
        chk("R3 fall ignored value", 32'(cap_value), 32'(last_val));

        // R1 reset mid-run
        rst = 1'b1; steps(2);
        chk("R1 value after reset", 32'(cap_value), 32'h0);
        chk("R1 flag after reset", 32'(cap_flag), 32'h0);
        rst = 1'b0; steps(2);

        finish_run();
    end
endmodule